// File: doc/BRIEF.md
# User Deadline Timer Event Unit

The unit holds a single 64-bit timer control register. The low six bits name an interrupt vector. The remaining upper bits, with the low six bits forced to zero, form a deadline. Every cycle the deadline is compared, as an unsigned number, against a free-running 64-bit timestamp counter. Whenever the deadline is non-zero and does not exceed the counter, a timer event is pending.

A pending event is processed only when the core qualifiers allow it: the feature is enabled, the core runs in 64-bit mode at privilege level 3 with the user interrupt flag set, and it is neither shut down nor waiting for a startup signal. Processing emits a one-cycle set pulse that carries a one-hot 64-bit mask. The pulse sets the request bit selected by the stored vector in the user interrupt request register, and it clears the whole control register. If the core is parked in a low-power timed wait, the unit first raises a wake request and defers processing until the wait ends. While an event is ready to be taken, a hold output tells ordinary user-interrupt delivery to step aside.

A software write has priority over processing in the same cycle. Pending status is then recomputed from the newly written value.

Top module: `udt_event_unit`

## Requirements
- R1: After reset the control register reads 0, no event is pending, and set_valid, set_mask, wake_req and uintr_hold are all 0.
- R2: A write of value X is stored whole. No bit is reserved and no value is refused, so the next read returns X (deadline = X with bits 5:0 cleared, vector = X bits 5:0).
- R3: pending is 1 exactly when the deadline is non-zero and deadline <= tsc, compared unsigned over 64 bits. This is recomputed every cycle from the stored value and the present counter.
- R4: A deadline of zero (bits 63:6 all zero) never produces a pending event, whatever the vector bits and the counter hold. Writing such a value cancels any event that was pending.
- R5: An event is processed only if feat_en=1, long_mode=1, priv_lvl=3, uif=1, shutdown=0, wait_startup=0 and timed_wait=0 all hold while pending=1 and no write is presented.
- R6: In the cycle after a processing edge, set_valid is 1 for exactly one cycle, set_mask has only bit [vector] set, and the control register reads 0.
- R7: wake_req equals pending with all qualifiers of R5 except timed_wait, while timed_wait=1. No processing happens while timed_wait=1.
- R8: When a write and a processing opportunity meet in one cycle, the write wins. No pulse follows, and the register holds the written value.
- R9: uintr_hold is 1 exactly when pending is 1 and all qualifiers of R5 other than timed_wait hold.
- R10: set_mask is all zero whenever set_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control register |
| cfg_wr_data | input | 64 | Value to write |
| cfg_rd_data | output | 64 | Current control register value |
| tsc | input | 64 | Timestamp counter |
| feat_en | input | 1 | Feature enable qualifier |
| long_mode | input | 1 | Core in 64-bit mode |
| priv_lvl | input | 2 | Current privilege level |
| uif | input | 1 | User interrupt flag |
| shutdown | input | 1 | Core in shutdown state |
| wait_startup | input | 1 | Core waiting for startup signal |
| timed_wait | input | 1 | Core in low-power timed wait |
| pending | output | 1 | Timer event pending |
| wake_req | output | 1 | Request to leave the timed wait |
| uintr_hold | output | 1 | Ordinary user-interrupt delivery must yield |
| set_valid | output | 1 | One-cycle request-bit set pulse |
| set_mask | output | 64 | One-hot request bit to set |

## Verification
The assertions check four things on every cycle: the set pulse is one-hot and its mask is zero when idle, a write lands intact, processing always leaves the register cleared, and a wake request only appears during a timed wait. Only the bench scenarios can show the rest. These are the exact compare boundary (deadline equal to the counter, one below it, and the top bit of an unsigned compare), the full sweep of 256 qualifier combinations against computed fire, wake and hold outcomes, the mask for each of the 64 vectors, and the write-over-processing race.

// File: rtl/udt_event_unit.sv
module udt_event_unit #(
  parameter int DW = 64,
  parameter int VW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [DW-1:0]        cfg_wr_data,
  output logic [DW-1:0]        cfg_rd_data,
  input  logic [DW-1:0]        tsc,
  input  logic                 feat_en,
  input  logic                 long_mode,
  input  logic [1:0]           priv_lvl,
  input  logic                 uif,
  input  logic                 shutdown,
  input  logic                 wait_startup,
  input  logic                 timed_wait,
  output logic                 pending,
  output logic                 wake_req,
  output logic                 uintr_hold,
  output logic                 set_valid,
  output logic [(1<<VW)-1:0]   set_mask
);
  localparam int NREQ = 1 << VW;

  logic [DW-1:0] ctl_q;
  logic [VW-1:0] vec;
  logic [DW-1:0] deadline;
  logic          gate_ok;
  logic          fire;

  assign vec         = ctl_q[VW-1:0];
  assign deadline    = {ctl_q[DW-1:VW], {VW{1'b0}}};
  assign cfg_rd_data = ctl_q;

  assign pending    = (|deadline) && (deadline <= tsc);
  assign gate_ok    = feat_en & long_mode & (priv_lvl == 2'd3) & uif & ~shutdown & ~wait_startup;
  assign uintr_hold = pending & gate_ok;
  assign wake_req   = uintr_hold & timed_wait;
  assign fire       = uintr_hold & ~timed_wait & ~cfg_wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      set_valid <= 1'b0;
      set_mask  <= '0;
    end else begin
      set_valid <= fire;
      set_mask  <= fire ? ({{(NREQ-1){1'b0}}, 1'b1} << vec) : '0;
      if (cfg_wr_en)
        ctl_q <= cfg_wr_data;
      else if (fire)
        ctl_q <= '0;
    end
  end

  assert_pulse_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> ($countones(set_mask) == 1));

  assert_idle_mask_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !set_valid |-> (set_mask == '0));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (cfg_rd_data == $past(cfg_wr_data)));

  assert_write_beats_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> !set_valid);

  assert_clear_after_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && !$past(cfg_wr_en)) |-> (cfg_rd_data == '0));

  assert_wake_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (timed_wait && pending));

  assert_no_fire_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timed_wait |=> !set_valid);
endmodule

// File: tb/sim_udt_event_unit.sv
`timescale 1ns/1ps
module sim_udt_event_unit;
  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0;
  logic [63:0] cfg_wr_data = '0, cfg_rd_data, tsc = '0;
  logic feat_en = 0, long_mode = 0, uif = 0, shutdown = 0, wait_startup = 0, timed_wait = 0;
  logic [1:0] priv_lvl = 0;
  logic pending, wake_req, uintr_hold, set_valid;
  logic [63:0] set_mask;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  udt_event_unit u0 (.clk, .rst_n, .cfg_wr_en, .cfg_wr_data, .cfg_rd_data, .tsc,
    .feat_en, .long_mode, .priv_lvl, .uif, .shutdown, .wait_startup, .timed_wait,
    .pending, .wake_req, .uintr_hold, .set_valid, .set_mask);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic gates_on();
    feat_en = 1; long_mode = 1; priv_lvl = 3; uif = 1;
    shutdown = 0; wait_startup = 0; timed_wait = 0;
  endtask

  task automatic wr(logic [63:0] v);
    cfg_wr_en = 1; cfg_wr_data = v; tick(); cfg_wr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [63:0] lfsr;
    lfsr = 64'hACE1_2468_9BDF_1357;
    repeat (3) tick();
    chk("R1 rd", cfg_rd_data, 0);
    chk("R1 flags", {pending, wake_req, uintr_hold, set_valid}, 0);
    chk("R1 mask", set_mask, 0);
    rst_n = 1;

    // R2: readback, gates off so nothing is consumed
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      wr(lfsr);
      chk("R2 readback", cfg_rd_data, lfsr);
    end

    // R3 boundaries, gates off
    wr(64'h0000_0000_0001_0005);
    tsc = 64'h0000_0000_0000_FFFF; #1; chk("R3 below", pending, 0);
    tsc = 64'h0000_0000_0001_0000; #1; chk("R3 equal", pending, 1);
    tsc = 64'h0000_0000_0001_0001; #1; chk("R3 above", pending, 1);
    wr(64'h8000_0000_0000_0000);
    tsc = 64'h7FFF_FFFF_FFFF_FFFF; #1; chk("R3 unsigned below", pending, 0);
    tsc = 64'hFFFF_FFFF_FFFF_FFFF; #1; chk("R3 unsigned above", pending, 1);

    // R4: zero deadline with every vector
    for (int v = 0; v < 64; v++) begin
      wr(64'(v));
      chk("R4 zero deadline", {pending, uintr_hold}, 0);
    end
    wr(64'h40); #1; chk("R4 pending before cancel", pending, 1);
    wr(64'h3F); chk("R4 cancel", pending, 0);

    // R6: each vector fires its own mask
    gates_on(); tsc = 64'd1000;
    for (int v = 0; v < 64; v++) begin
      cfg_wr_en = 1; cfg_wr_data = 64'h200 | 64'(v); tick(); cfg_wr_en = 0;
      chk("R6 no pulse on write edge", set_valid, 0);
      tick();
      chk("R6 valid", set_valid, 1);
      chk("R6 mask", set_mask, 64'd1 << v);
      chk("R6 cleared", cfg_rd_data, 0);
      tick();
      chk("R6 single pulse", set_valid, 0);
      chk("R10 idle mask", set_mask, 0);
    end

    // R5/R7/R9: qualifier sweep
    for (int c = 0; c < 256; c++) begin
      logic g, f;
      feat_en = c[0]; long_mode = c[1]; priv_lvl = c[3:2]; uif = c[4];
      shutdown = c[5]; wait_startup = c[6]; timed_wait = c[7];
      g = c[0] & c[1] & (c[3:2] == 2'd3) & c[4] & ~c[5] & ~c[6];
      f = g & ~c[7];
      wr(64'h1C0 | 64'(c % 64));
      chk("R9 hold", uintr_hold, g);
      chk("R7 wake", wake_req, g & c[7]);
      tick();
      chk("R5 fire", set_valid, f);
      chk("R5 mask", set_mask, f ? (64'd1 << (c % 64)) : 64'd0);
      chk("R5 register", cfg_rd_data, f ? 64'd0 : (64'h1C0 | 64'(c % 64)));
    end

    // R7: leave the wait, then process
    gates_on(); timed_wait = 1;
    wr(64'h105); tick(); tick();
    chk("R7 held off", set_valid, 0);
    chk("R7 wake held", wake_req, 1);
    timed_wait = 0; tick();
    chk("R7 fires after wake", set_valid, 1);
    chk("R7 mask", set_mask, 64'd1 << 5);

    // R8: write collides with ready event
    wr(64'h0C7); #1; chk("R8 ready", uintr_hold, 1);
    cfg_wr_en = 1; cfg_wr_data = 64'hFFFF_0000_0000_0009; tick(); cfg_wr_en = 0;
    chk("R8 no pulse", set_valid, 0);
    chk("R8 new value", cfg_rd_data, 64'hFFFF_0000_0000_0009);
    chk("R8 re-evaluated", pending, 0);
    tick();
    chk("R8 still no pulse", set_valid, 0);

    finish_run();
  end
endmodule